// File: doc/BRIEF.md
# MAC Internal Loopback Switch

This block sits between a media access controller and the MII-style signals of its PHY. In normal operation it is transparent. Receive data, valid, error, carrier sense, collision and both PHY clocks go to the MAC unchanged, and the MAC's transmit data and enable go to the PHY unchanged. A separate loopback request from the MAC is always forwarded to the PHY, so that the PHY can perform its own loopback.

When internal loopback is active, the block turns the MAC's transmit stream back into its receive stream. Transmit enable becomes receive valid, and transmit data becomes receive data. Full duplex is forced, the PHY-side error and line-status inputs are masked, and the transmitter toward the PHY is held quiet. Both MAC clocks are then taken from the system clock divided by a parameterised even ratio, with a 50% duty cycle. The mode may only change while the receiver and the transmitter are both disabled, because the clocks switch source at that moment. A request made while either one is enabled is refused: the mode is held and an error flag is raised.

Top module: `mac_loop_switch`

## Requirements
- R1: With loopback inactive, `mac_rxd`, `mac_rx_dv`, `mac_rx_er`, `mac_crs`, `mac_col`, `mac_rx_clk` and `mac_tx_clk` equal the matching PHY inputs in the same cycle.
- R2: With loopback inactive, `phy_txd` and `phy_tx_en` equal `mac_txd` and `mac_tx_en`. With loopback active, both are held at 0.
- R3: With loopback active, `mac_rxd` equals `mac_txd` and `mac_rx_dv` equals `mac_tx_en` in the same cycle, and the PHY receive data is ignored.
- R4: `mac_full_duplex` is 1 while loopback is active, and otherwise follows `cfg_full_duplex`.
- R5: With loopback active, `mac_rx_er`, `mac_crs` and `mac_col` are 0 whatever the PHY drives.
- R6: With loopback active, `mac_rx_clk` and `mac_tx_clk` are the same signal, with a period of DIV system clocks and DIV/2 high. The loop clock is low while loopback is inactive. Counting the edge at which loopback becomes active as edge 0, its first rise comes at edge DIV/2.
- R7: `phy_loopback` equals `lb_req` at all times, in either mode.
- R8: A value on `llb_req` is taken into `llb_active` at a clock edge only if `rx_en` and `tx_en` are both 0 in that cycle. `llb_active` = 1 means loopback.
- R9: If `llb_req` differs from `llb_active` while `rx_en` or `tx_en` is 1, the mode is held and `mode_err` is 1 after the next edge. `mode_err` returns to 0 one edge after the request matches the mode again or both enables are 0.
- R10: During reset, `llb_active` and `mode_err` are 0, the loop clock is low, and the block is in pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| llb_req | input | 1 | Internal loopback request |
| lb_req | input | 1 | PHY loopback request |
| rx_en | input | 1 | MAC receiver enabled |
| tx_en | input | 1 | MAC transmitter enabled |
| cfg_full_duplex | input | 1 | Configured duplex (1 = full) |
| mac_txd | input | DATA_W | Transmit data from the MAC |
| mac_tx_en | input | 1 | Transmit enable from the MAC |
| phy_rxd | input | DATA_W | Receive data from the PHY |
| phy_rx_dv | input | 1 | Receive valid from the PHY |
| phy_rx_er | input | 1 | Receive error from the PHY |
| phy_crs | input | 1 | Carrier sense from the PHY |
| phy_col | input | 1 | Collision from the PHY |
| phy_rx_clk | input | 1 | Receive clock from the PHY |
| phy_tx_clk | input | 1 | Transmit clock from the PHY |
| mac_rxd | output | DATA_W | Receive data to the MAC |
| mac_rx_dv | output | 1 | Receive valid to the MAC |
| mac_rx_er | output | 1 | Receive error to the MAC |
| mac_crs | output | 1 | Carrier sense to the MAC |
| mac_col | output | 1 | Collision to the MAC |
| mac_rx_clk | output | 1 | Receive clock to the MAC |
| mac_tx_clk | output | 1 | Transmit clock to the MAC |
| mac_full_duplex | output | 1 | Effective duplex to the MAC |
| phy_txd | output | DATA_W | Transmit data to the PHY |
| phy_tx_en | output | 1 | Transmit enable to the PHY |
| phy_loopback | output | 1 | Loopback request to the PHY |
| llb_active | output | 1 | Internal loopback currently in force |
| mode_err | output | 1 | Refused mode change |

## Verification
The bench builds the block with DATA_W = 4, DIV = 4 and LOOP_STAGE = 0. In this build the loopback data path is combinational, so every data, duplex and status output can be predicted for the same cycle in which its inputs were driven. With DIV = 4, a half period is two system clocks. This short ratio lets the bench check the loop clock's exact phase after entry, its duty cycle and its period within twelve samples, while each refused or accepted mode change still stays within a few cycles.

// File: rtl/mls_pkg.sv
package mls_pkg;
   typedef enum logic {
      MODE_PASS = 1'b0,
      MODE_LOOP = 1'b1
   } mls_mode_e;

   function automatic int unsigned half_of(input int unsigned div);
      return div / 2;
   endfunction
endpackage

// File: rtl/mls_mode_ctrl.sv
module mls_mode_ctrl
   import mls_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      llb_req,
   input  logic      rx_en,
   input  logic      tx_en,
   output mls_mode_e mode,
   output logic      mode_err
);
   mls_mode_e mode_q;
   logic      err_q;
   logic      busy;
   mls_mode_e want;

   assign busy = rx_en | tx_en;
   assign want = llb_req ? MODE_LOOP : MODE_PASS;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_PASS;
         err_q  <= 1'b0;
      end else begin
         if (!busy)
            mode_q <= want;
         err_q <= busy && (want != mode_q);
      end
   end

   assign mode     = mode_q;
   assign mode_err = err_q;

   // R8: an enabled datapath freezes the mode
   p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> mode_q == $past(mode_q));
   // R9: an error is only ever reported after a cycle with a datapath enabled
   p_err_needs_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> $past(busy));
   // R8: when idle, the request is taken at the next edge
   p_take_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> mode_q == $past(want));
endmodule

// File: rtl/mls_clk_div.sv
module mls_clk_div #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic lclk
);
   localparam int unsigned HALF = mls_pkg::half_of(DIV);
   localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF - 1);

   generate
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("mls_clk_div: DIV must be even and at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          lclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         lclk_q <= 1'b0;
      end else if (!run) begin
         cnt_q  <= '0;
         lclk_q <= 1'b0;
      end else if (cnt_q == LAST) begin
         cnt_q  <= '0;
         lclk_q <= ~lclk_q;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign lclk = lclk_q;

   // R6: the loop clock rests low outside loopback
   p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !lclk_q);

   generate
      if (HALF > 1) begin : g_wide_half
         // R6: a new level is held for more than one system clock
         p_hold_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (run && $rose(lclk_q)) |=> (lclk_q || !$past(run)));
      end
   endgenerate
endmodule

// File: rtl/mls_path_mux.sv
module mls_path_mux #(
   parameter int unsigned DATA_W     = 4,
   parameter bit          LOOP_STAGE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              loop,
   input  logic              lclk,
   input  logic              cfg_full_duplex,
   input  logic [DATA_W-1:0] mac_txd,
   input  logic              mac_tx_en,
   input  logic [DATA_W-1:0] phy_rxd,
   input  logic              phy_rx_dv,
   input  logic              phy_rx_er,
   input  logic              phy_crs,
   input  logic              phy_col,
   input  logic              phy_rx_clk,
   input  logic              phy_tx_clk,
   output logic [DATA_W-1:0] mac_rxd,
   output logic              mac_rx_dv,
   output logic              mac_rx_er,
   output logic              mac_crs,
   output logic              mac_col,
   output logic              mac_rx_clk,
   output logic              mac_tx_clk,
   output logic              mac_full_duplex,
   output logic [DATA_W-1:0] phy_txd,
   output logic              phy_tx_en
);
   logic [DATA_W-1:0] lp_d;
   logic              lp_v;

   generate
      if (LOOP_STAGE) begin : g_staged
         logic [DATA_W-1:0] d_q;
         logic              v_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               d_q <= '0;
               v_q <= 1'b0;
            end else begin
               d_q <= loop ? mac_txd : '0;
               v_q <= loop & mac_tx_en;
            end
         end
         assign lp_d = d_q;
         assign lp_v = v_q;
      end else begin : g_direct
         assign lp_d = mac_txd;
         assign lp_v = mac_tx_en;
         // R3: transmit enable reappears as receive valid
         p_loop_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
            loop |-> (mac_rx_dv == mac_tx_en));
      end
   endgenerate

   always_comb begin
      if (loop) begin
         mac_rxd         = lp_d;
         mac_rx_dv       = lp_v;
         mac_rx_er       = 1'b0;
         mac_crs         = 1'b0;
         mac_col         = 1'b0;
         mac_rx_clk      = lclk;
         mac_tx_clk      = lclk;
         mac_full_duplex = 1'b1;
         phy_txd         = '0;
         phy_tx_en       = 1'b0;
      end else begin
         mac_rxd         = phy_rxd;
         mac_rx_dv       = phy_rx_dv;
         mac_rx_er       = phy_rx_er;
         mac_crs         = phy_crs;
         mac_col         = phy_col;
         mac_rx_clk      = phy_rx_clk;
         mac_tx_clk      = phy_tx_clk;
         mac_full_duplex = cfg_full_duplex;
         phy_txd         = mac_txd;
         phy_tx_en       = mac_tx_en;
      end
   end

   // R5: line status is silenced during loopback
   p_quiet_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
      loop |-> !(mac_rx_er || mac_crs || mac_col));
   // R4: duplex is forced to full during loopback
   p_full_duplex_r4: assert property (@(posedge clk) disable iff (!rst_n)
      loop |-> mac_full_duplex);
   // R2: nothing reaches the PHY transmitter during loopback
   p_phy_tx_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      loop |-> !phy_tx_en);
endmodule

// File: rtl/mac_loop_switch.sv
module mac_loop_switch
   import mls_pkg::*;
#(
   parameter int unsigned DATA_W     = 4,
   parameter int unsigned DIV        = 4,
   parameter bit          LOOP_STAGE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              llb_req,
   input  logic              lb_req,
   input  logic              rx_en,
   input  logic              tx_en,
   input  logic              cfg_full_duplex,
   input  logic [DATA_W-1:0] mac_txd,
   input  logic              mac_tx_en,
   input  logic [DATA_W-1:0] phy_rxd,
   input  logic              phy_rx_dv,
   input  logic              phy_rx_er,
   input  logic              phy_crs,
   input  logic              phy_col,
   input  logic              phy_rx_clk,
   input  logic              phy_tx_clk,
   output logic [DATA_W-1:0] mac_rxd,
   output logic              mac_rx_dv,
   output logic              mac_rx_er,
   output logic              mac_crs,
   output logic              mac_col,
   output logic              mac_rx_clk,
   output logic              mac_tx_clk,
   output logic              mac_full_duplex,
   output logic [DATA_W-1:0] phy_txd,
   output logic              phy_tx_en,
   output logic              phy_loopback,
   output logic              llb_active,
   output logic              mode_err
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("mac_loop_switch: DATA_W must be at least 1");
      end
   endgenerate

   mls_mode_e mode;
   logic      loop;
   logic      lclk;

   mls_mode_ctrl u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .llb_req  (llb_req),
      .rx_en    (rx_en),
      .tx_en    (tx_en),
      .mode     (mode),
      .mode_err (mode_err)
   );

   assign loop       = (mode == MODE_LOOP);
   assign llb_active = loop;

   mls_clk_div #(.DIV(DIV)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (loop),
      .lclk  (lclk)
   );

   mls_path_mux #(.DATA_W(DATA_W), .LOOP_STAGE(LOOP_STAGE)) u_mux (
      .clk             (clk),
      .rst_n           (rst_n),
      .loop            (loop),
      .lclk            (lclk),
      .cfg_full_duplex (cfg_full_duplex),
      .mac_txd         (mac_txd),
      .mac_tx_en       (mac_tx_en),
      .phy_rxd         (phy_rxd),
      .phy_rx_dv       (phy_rx_dv),
      .phy_rx_er       (phy_rx_er),
      .phy_crs         (phy_crs),
      .phy_col         (phy_col),
      .phy_rx_clk      (phy_rx_clk),
      .phy_tx_clk      (phy_tx_clk),
      .mac_rxd         (mac_rxd),
      .mac_rx_dv       (mac_rx_dv),
      .mac_rx_er       (mac_rx_er),
      .mac_crs         (mac_crs),
      .mac_col         (mac_col),
      .mac_rx_clk      (mac_rx_clk),
      .mac_tx_clk      (mac_tx_clk),
      .mac_full_duplex (mac_full_duplex),
      .phy_txd         (phy_txd),
      .phy_tx_en       (phy_tx_en)
   );

   assign phy_loopback = lb_req;

   // R6: both MAC clocks come from the one divider during loopback
   p_clocks_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      loop |-> (mac_rx_clk == mac_tx_clk));
   // R8: the mode only flips at an edge where both datapaths were off
   p_flip_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (loop != $past(loop)) |-> !$past(rx_en || tx_en));
endmodule

// File: tb/test_mac_loop_switch.sv
module test_mac_loop_switch;
   localparam int DW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          llb_req = 0, lb_req = 0, rx_en = 0, tx_en = 0, cfg_fd = 0;
   logic [DW-1:0] mac_txd = '0, phy_rxd = '0;
   logic          mac_tx_en = 0, phy_rx_dv = 0, phy_rx_er = 0, phy_crs = 0, phy_col = 0;
   logic          phy_rx_clk = 0, phy_tx_clk = 0;

   logic [DW-1:0] mac_rxd, phy_txd;
   logic          mac_rx_dv, mac_rx_er, mac_crs, mac_col, mac_rx_clk, mac_tx_clk;
   logic          mac_full_duplex, phy_tx_en, phy_loopback, llb_active, mode_err;

   mac_loop_switch #(.DATA_W(DW), .DIV(4), .LOOP_STAGE(1'b0)) i_mac_loop_switch (
      .clk(clk), .rst_n(rst_n), .llb_req(llb_req), .lb_req(lb_req),
      .rx_en(rx_en), .tx_en(tx_en), .cfg_full_duplex(cfg_fd),
      .mac_txd(mac_txd), .mac_tx_en(mac_tx_en), .phy_rxd(phy_rxd),
      .phy_rx_dv(phy_rx_dv), .phy_rx_er(phy_rx_er), .phy_crs(phy_crs),
      .phy_col(phy_col), .phy_rx_clk(phy_rx_clk), .phy_tx_clk(phy_tx_clk),
      .mac_rxd(mac_rxd), .mac_rx_dv(mac_rx_dv), .mac_rx_er(mac_rx_er),
      .mac_crs(mac_crs), .mac_col(mac_col), .mac_rx_clk(mac_rx_clk),
      .mac_tx_clk(mac_tx_clk), .mac_full_duplex(mac_full_duplex),
      .phy_txd(phy_txd), .phy_tx_en(phy_tx_en), .phy_loopback(phy_loopback),
      .llb_active(llb_active), .mode_err(mode_err)
   );

   int total = 0;
   int bad = 0;
   int cyc = 0;

   // scoreboard queues, observed vector layout:
   // {rx_clk, tx_clk, active, err, phy_lb, fd, phy_tx_en, phy_txd[3:0], col, crs, rx_er, rx_dv, rxd[3:0]}
   logic [18:0] exp_q[$];
   logic [18:0] msk_q[$];
   string       tag_q[$];

   // bench model of the mode state
   logic m_llb = 0;
   logic m_err = 0;

   function automatic logic [18:0] observe();
      return {mac_rx_clk, mac_tx_clk, llb_active, mode_err, phy_loopback, mac_full_duplex,
              phy_tx_en, phy_txd, mac_col, mac_crs, mac_rx_er, mac_rx_dv, mac_rxd};
   endfunction

   task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
      end
   endtask

   // driver: applies one cycle of stimulus and queues the predicted outputs
   task automatic step(input logic llb, input logic lb, input logic re, input logic te,
                       input logic fd, input logic [DW-1:0] txd, input logic txv,
                       input logic [DW-1:0] rxd, input logic rxv, input logic rxe,
                       input logic crs, input logic col, input logic rck,
                       input logic tck, input string tag);
      logic [18:0] e;
      logic [18:0] m;
      logic        nerr;
      @(posedge clk);
      #1;
      llb_req = llb; lb_req = lb; rx_en = re; tx_en = te; cfg_fd = fd;
      mac_txd = txd; mac_tx_en = txv; phy_rxd = rxd; phy_rx_dv = rxv;
      phy_rx_er = rxe; phy_crs = crs; phy_col = col; phy_rx_clk = rck; phy_tx_clk = tck;
      m = '1;
      if (m_llb) begin
         e = {2'b00, 1'b1, m_err, lb, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, txv, txd};
         m[18:17] = 2'b00;
      end else begin
         e = {rck, tck, 1'b0, m_err, lb, fd, txv, txd, col, crs, rxe, rxv, rxd};
      end
      exp_q.push_back(e);
      msk_q.push_back(m);
      tag_q.push_back(tag);
      nerr = (re | te) & (llb != m_llb);
      if (!re && !te) m_llb = llb;
      m_err = nerr;
   endtask

   // monitor: compares at the falling edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [18:0] e;
         logic [18:0] m;
         string       t;
         e = exp_q.pop_front();
         m = msk_q.pop_front();
         t = tag_q.pop_front();
         check(t, observe() & m, e & m);
      end
   end

   // watchdog
   always @(negedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic s_rx[12];
      logic s_tx[12];

      // R10: reset state, PHY inputs visible in pass-through
      phy_rxd = 4'hA; phy_rx_dv = 1; phy_crs = 1; phy_rx_clk = 1; lb_req = 1;
      repeat (3) @(negedge clk);
      check("R10 reset", observe(),
            {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hA});
      @(posedge clk); #1 rst_n = 1;

      // R1 R2 R4 R7: pass-through patterns
      for (int i = 0; i < 8; i++)
         step(0, i[1], i[0], i[2], i[0], 4'(i * 3), i[1], 4'(15 - i), i[0], i[2],
              i[1], ~i[0], i[0], ~i[1], "R1 R2 R4 R7 pass");

      // R8: enter loopback with both enables off
      step(1, 0, 0, 0, 0, 4'h0, 0, 4'h5, 1, 1, 1, 1, 0, 0, "R8 enter request");
      @(negedge clk);
      // R6: loop clock phase, duty and period after entry
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         s_rx[i] = mac_rx_clk;
         s_tx[i] = mac_tx_clk;
      end
      for (int i = 0; i < 12; i++) begin
         check("R6 loop rx clock", {18'h0, s_rx[i]}, {18'h0, logic'((i % 4) >= 2)});
         check("R6 loop tx clock", {18'h0, s_tx[i]}, {18'h0, logic'((i % 4) >= 2)});
      end

      // R3 R5 R4 R2 R7: loop data, PHY inputs active and ignored
      for (int i = 0; i < 16; i++)
         step(1, i[2], 0, 0, 0, 4'(i), i[0], 4'(~i), ~i[0], 1, 1, 1, i[0], i[1],
              "R3 R5 R4 R2 R7 loop");

      // R9: request exit while receiver enabled -> held, error
      step(0, 0, 1, 0, 0, 4'h3, 1, 4'hC, 0, 1, 1, 1, 0, 0, "R9 refused exit rx");
      step(0, 0, 1, 0, 0, 4'h6, 0, 4'hC, 1, 1, 1, 1, 0, 0, "R9 held mode");
      step(1, 0, 1, 0, 0, 4'h9, 1, 4'hC, 1, 1, 1, 1, 0, 0, "R9 request matches");
      step(1, 0, 1, 0, 0, 4'h1, 1, 4'hC, 1, 1, 1, 1, 0, 0, "R9 error cleared");
      // R9 R8: transmitter enabled also blocks
      step(0, 1, 0, 1, 1, 4'hE, 1, 4'h2, 1, 1, 1, 1, 1, 1, "R9 refused exit tx");
      step(0, 1, 0, 1, 1, 4'hF, 0, 4'h2, 1, 1, 1, 1, 1, 1, "R8 still looped");
      // R8: both off -> exit takes effect next edge
      step(0, 0, 0, 0, 1, 4'h7, 1, 4'h4, 1, 0, 1, 0, 1, 0, "R8 exit accepted");
      for (int i = 0; i < 6; i++)
         step(0, i[0], 0, 0, i[1], 4'(i + 8), i[0], 4'(i), ~i[0], i[1], i[0],
              i[2], ~i[1], i[0], "R1 R2 R8 pass again");
      // R9: entry refused while receiver enabled
      step(1, 0, 1, 1, 0, 4'hB, 1, 4'hD, 1, 0, 0, 0, 1, 1, "R9 refused entry");
      step(1, 0, 1, 1, 0, 4'hB, 1, 4'hD, 1, 0, 0, 0, 1, 1, "R9 entry held");
      step(0, 0, 0, 0, 0, 4'h0, 0, 4'h0, 0, 0, 0, 0, 0, 0, "R9 idle clear");
      step(0, 0, 0, 0, 0, 4'h0, 0, 4'h1, 0, 0, 0, 0, 0, 0, "R1 final");

      repeat (3) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule